// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block gathers eight interrupt request lines into a single interrupt output for a processor. Each line is captured into a request register, either on a rising edge or by following its level. A mask register can hold back any line. A fixed-priority resolver then chooses the lowest-numbered pending, unmasked line, where line 0 has the highest priority. The interrupt output is raised only when that line outranks every line the processor is already servicing.

When the processor pulses its acknowledge input, the winning line moves from the request register into the in-service register. One cycle later the block presents an 8-bit vector number. The upper five bits of the vector come from a programmable base and the lower three bits are the line number. A command write ends service of the highest-priority line in service, which allows nested interrupts to unwind in order. All settings are reached through a small synchronous register port: a 2-bit address, a write strobe, write data and combinational read data.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request, mask and in-service registers read 0, the configuration reads 0 (edge capture, vector base 0), `cpu_irq` is low and `vec_valid` is low.
- R2: In edge capture, a request bit is set at the first clock edge where the line is high and was low at the previous edge. The bit stays set after the line drops and is cleared only by an acknowledge. A line held high through its acknowledge is not captured again until it has been seen low. The request register reads at address 3.
- R3: In level capture (configuration bit 0 = 1), each request bit equals the line value sampled at the last clock edge, and an acknowledge does not clear it.
- R4: The mask register (address 0, bit n masks line n) keeps a masked line from raising `cpu_irq`, while its request bit is still recorded. Clearing the mask lets the line raise `cpu_irq`.
- R5: `cpu_irq` is high exactly when some pending unmasked line exists and the lowest-numbered such line has a lower number than every set in-service bit (or no in-service bit is set).
- R6: A `cpu_ack` pulse while `cpu_irq` is high sets the winning line's in-service bit and, in edge capture, clears its request bit. At the next sample `vec_valid` is high for one cycle with `vec_num` = {base, line[2:0]}. A `cpu_ack` while `cpu_irq` is low changes nothing and gives no `vec_valid`.
- R7: Any write to address 2 is an end-of-service command that clears the lowest-numbered set in-service bit. It has no effect on an empty in-service register. The in-service register reads at address 2.
- R8: When an end-of-service command and a taken acknowledge fall in the same cycle, the command acts on the in-service register as it was before that cycle, and then the new line's bit is set.
- R9: The configuration register at address 1 holds the capture mode in bit 0 and the vector base in bits 7:3. Bits 2:1 read as 0.
- R10: Writes to address 3 are ignored: mask, configuration and request state are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 8 | Interrupt request lines, line 0 highest priority |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| cpu_irq | output | 1 | Interrupt request to the processor |
| cpu_ack | input | 1 | Acknowledge pulse from the processor |
| vec_valid | output | 1 | Vector number valid, one cycle |
| vec_num | output | 8 | Vector number {base, line} |

## Verification
A line change or register write is registered at the next clock edge. After that edge, `cpu_irq` and `bus_rdata` follow combinationally from the new state, so both are due one edge after the stimulus. The vector and `vec_valid` are due one edge after the acknowledge that took them. The bench drives every input 1 ns after a rising edge and samples all outputs 1 ns after the next rising edge. At that point it compares them with a behavioural model that has advanced exactly one step on the same inputs. Directed sequences for the nesting, masking, same-cycle command and capture-mode cases are followed by a long random phase that uses the same per-cycle comparison.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
  localparam int unsigned IRQ_LINES = 8;
  localparam int unsigned IDX_W     = $clog2(IRQ_LINES);
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned BASE_W    = DATA_W - IDX_W;
  localparam int unsigned ADDR_W    = 2;

  typedef logic [IRQ_LINES-1:0] irq_vec_t;
  typedef logic [IDX_W-1:0]     irq_idx_t;

  // register map; the command address is decoded as end-of-service
  localparam logic [ADDR_W-1:0] ADR_MASK = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_CFG  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_CMD  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_REQ  = ADDR_W'(3);
  localparam int unsigned CFG_LEVEL_BIT = 0;

  // one-hot of the lowest set bit (highest priority)
  function automatic irq_vec_t lowest_oh(irq_vec_t v);
    return v & (~v + irq_vec_t'(1));
  endfunction

  function automatic irq_idx_t lowest_idx(irq_vec_t v);
    irq_idx_t r = '0;
    for (int i = IRQ_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = irq_idx_t'(i);
    end
    return r;
  endfunction

  // pending work outranks everything currently in service
  function automatic logic outranks(irq_vec_t pend, irq_vec_t busy);
    return (pend != '0) && ((busy == '0) || (lowest_oh(pend) < lowest_oh(busy)));
  endfunction

  function automatic logic [DATA_W-1:0] make_vector(logic [BASE_W-1:0] base, irq_idx_t idx);
    return {base, idx};
  endfunction
endpackage

// File: rtl/pic_req_capture.sv
module pic_req_capture
  import pic8_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t irq_lines,
  input  logic     level_mode,
  input  irq_vec_t clr,
  output irq_vec_t irr_q,
  output irq_vec_t irq_rise
);
  irq_vec_t prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= irq_lines;
  end

  assign irq_rise = irq_lines & ~prev_q;

  for (genvar g = 0; g < IRQ_LINES; g++) begin : g_bit
    logic bit_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bit_q <= 1'b0;
      else if (level_mode) bit_q <= irq_lines[g];
      else                 bit_q <= (bit_q & ~clr[g]) | irq_rise[g];
    end

    assign irr_q[g] = bit_q;

    // R2: an edge-captured request holds until acknowledged
    p_edge_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && bit_q && !clr[g]) |=> bit_q);

    // R2: a rising edge is always captured
    p_rise_latches_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && irq_rise[g]) |=> bit_q);
  end

  // R3: level capture follows the sampled line
  p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode |=> (irr_q == $past(irq_lines)));
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic8_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t irr_q,
  input  irq_vec_t mask_q,
  input  irq_vec_t isr_q,
  output irq_vec_t pending,
  output irq_vec_t win_oh,
  output irq_idx_t win_idx,
  output logic     cpu_irq
);
  assign pending = irr_q & ~mask_q;
  assign win_oh  = lowest_oh(pending);
  assign win_idx = lowest_idx(pending);
  assign cpu_irq = outranks(pending, isr_q);

  // R4: fully masked requests never interrupt
  p_masked_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_q & ~mask_q) == '0) |-> !cpu_irq);

  // R5: line 0 in service blocks every other line
  p_top_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    isr_q[0] |-> !cpu_irq);

  // R5: a single winner at most
  p_one_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh));
endmodule

// File: rtl/pic_service.sv
module pic_service
  import pic8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ack,
  input  logic              cpu_irq,
  input  irq_vec_t          win_oh,
  input  irq_idx_t          win_idx,
  input  logic              eoi_cmd,
  input  logic [BASE_W-1:0] vec_base,
  output irq_vec_t          isr_q,
  output logic              ack_take,
  output logic              vec_valid,
  output logic [DATA_W-1:0] vec_num
);
  irq_vec_t eoi_clr;
  irq_vec_t ack_set;

  assign ack_take = cpu_ack & cpu_irq;
  assign eoi_clr  = eoi_cmd  ? lowest_oh(isr_q) : '0;
  assign ack_set  = ack_take ? win_oh : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q     <= '0;
      vec_valid <= 1'b0;
      vec_num   <= '0;
    end else begin
      isr_q     <= (isr_q & ~eoi_clr) | ack_set;
      vec_valid <= ack_take;
      if (ack_take) vec_num <= make_vector(vec_base, win_idx);
    end
  end

  // R6: the taken line enters service and its vector follows
  p_isr_gets_winner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> ((isr_q & $past(win_oh)) != '0));

  p_vec_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (vec_valid && vec_num[IDX_W-1:0] == $past(win_idx)));

  p_no_vec_without_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_take |=> !vec_valid);

  // R7: end-of-service removes exactly one bit
  p_eoi_clears_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && !ack_take && isr_q != '0) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  irq_vec_t          irr_q,
  input  irq_vec_t          isr_q,
  output irq_vec_t          mask_q,
  output logic              level_mode,
  output logic [BASE_W-1:0] vec_base,
  output logic              eoi_cmd,
  output logic [DATA_W-1:0] bus_rdata
);
  logic wr_mask, wr_cfg;

  assign wr_mask = bus_wr && (bus_addr == ADR_MASK);
  assign wr_cfg  = bus_wr && (bus_addr == ADR_CFG);
  assign eoi_cmd = bus_wr && (bus_addr == ADR_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      level_mode <= 1'b0;
      vec_base   <= '0;
    end else begin
      if (wr_mask) mask_q <= bus_wdata[IRQ_LINES-1:0];
      if (wr_cfg) begin
        level_mode <= bus_wdata[CFG_LEVEL_BIT];
        vec_base   <= bus_wdata[DATA_W-1:IDX_W];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      ADR_MASK: bus_rdata = DATA_W'(mask_q);
      ADR_CFG:  bus_rdata = {vec_base, {(IDX_W-1){1'b0}}, level_mode};
      ADR_CMD:  bus_rdata = DATA_W'(isr_q);
      default:  bus_rdata = DATA_W'(irr_q);
    endcase
  end

  // R10: the request address accepts no writes
  p_req_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_REQ) |=>
      ($stable(mask_q) && $stable(level_mode) && $stable(vec_base)));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic8_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  irq_lines,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        cpu_irq,
  input  logic        cpu_ack,
  output logic        vec_valid,
  output logic [7:0]  vec_num
);
  irq_vec_t          irr_q, irq_rise, mask_q, isr_q, pending, win_oh, req_clr;
  irq_idx_t          win_idx;
  logic              level_mode, eoi_cmd, ack_take;
  logic [BASE_W-1:0] vec_base;

  assign req_clr = ack_take ? win_oh : '0;

  pic_req_capture u_capture (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .level_mode(level_mode),
    .clr(req_clr), .irr_q(irr_q), .irq_rise(irq_rise)
  );

  pic_resolver u_resolver (
    .clk(clk), .rst_n(rst_n), .irr_q(irr_q), .mask_q(mask_q), .isr_q(isr_q),
    .pending(pending), .win_oh(win_oh), .win_idx(win_idx), .cpu_irq(cpu_irq)
  );

  pic_service u_service (
    .clk(clk), .rst_n(rst_n), .cpu_ack(cpu_ack), .cpu_irq(cpu_irq),
    .win_oh(win_oh), .win_idx(win_idx), .eoi_cmd(eoi_cmd), .vec_base(vec_base),
    .isr_q(isr_q), .ack_take(ack_take), .vec_valid(vec_valid), .vec_num(vec_num)
  );

  pic_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irr_q(irr_q), .isr_q(isr_q), .mask_q(mask_q),
    .level_mode(level_mode), .vec_base(vec_base), .eoi_cmd(eoi_cmd),
    .bus_rdata(bus_rdata)
  );

  // R8: command and acknowledge together leave the new line in service
  p_eoi_ack_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && ack_take) |=> ((isr_q & $past(win_oh)) != '0));

  // R6: a taken acknowledge removes the edge request
  p_ack_clears_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !level_mode && (irq_rise & win_oh) == '0) |=> ((irr_q & $past(win_oh)) == '0));

  logic unused_pending;
  assign unused_pending = ^pending;
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_lines = '0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cpu_irq;
  logic       cpu_ack = 1'b0;
  logic       vec_valid;
  logic [7:0] vec_num;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .vec_valid(vec_valid), .vec_num(vec_num)
  );

  // behavioural reference model
  logic [7:0] m_irr, m_mask, m_isr, m_prev, m_vec;
  logic [4:0] m_base;
  logic       m_level, m_vvalid;

  function automatic int first_set(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic logic m_int();
    return first_set(m_irr & ~m_mask) < first_set(m_isr);
  endfunction

  function automatic logic [7:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return m_mask;
      2'd1: return {m_base, 2'b00, m_level};
      2'd2: return m_isr;
      default: return m_irr;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [7:0] nirr, nisr;
    int w, e;
    logic take;
    if (!rst_n) begin
      m_irr = 0; m_mask = 0; m_isr = 0; m_prev = 0; m_vec = 0;
      m_base = 0; m_level = 0; m_vvalid = 0;
    end else begin
      take = cpu_ack && m_int();
      w = first_set(m_irr & ~m_mask);
      nisr = m_isr;
      if (bus_wr && bus_addr == 2'd2) begin
        e = first_set(nisr);
        if (e < 8) nisr[e] = 1'b0;
      end
      if (take) nisr[w] = 1'b1;
      for (int i = 0; i < 8; i++) begin
        if (m_level) nirr[i] = irq_lines[i];
        else nirr[i] = (m_irr[i] && !(take && w == i)) || (irq_lines[i] && !m_prev[i]);
      end
      if (take) m_vec = {m_base, 3'(w)};
      m_vvalid = take;
      m_irr = nirr;
      m_isr = nisr;
      m_prev = irq_lines;
      if (bus_wr && bus_addr == 2'd0) m_mask = bus_wdata;
      if (bus_wr && bus_addr == 2'd1) begin
        m_level = bus_wdata[0];
        m_base  = bus_wdata[7:3];
      end
    end
  end

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(logic [1:0] a);
    case (a)
      2'd0: return "R4";
      2'd1: return "R9";
      2'd2: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic compare_all();
    chk8("R5 cpu_irq", 8'(cpu_irq), 8'(m_int()));
    chk8("R6 vec_valid", 8'(vec_valid), 8'(m_vvalid));
    if (m_vvalid) chk8("R6 vec_num", vec_num, m_vec);
    chk8(rd_tag(bus_addr), bus_rdata, m_read(bus_addr));
  endtask

  // drive one cycle, then sample 1 ns after the edge
  task automatic cyc(logic [7:0] irq, logic wr, logic [1:0] a, logic [7:0] wd, logic ack);
    irq_lines = irq; bus_wr = wr; bus_addr = a; bus_wdata = wd; cpu_ack = ack;
    @(posedge clk); #1;
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    cyc(0, 0, 0, 0, 0); chk8("R1", bus_rdata, 8'h00); chk8("R1", 8'(cpu_irq), 0);
    cyc(0, 0, 1, 0, 0); chk8("R1", bus_rdata, 8'h00); chk8("R1", 8'(vec_valid), 0);
    cyc(0, 0, 2, 0, 0); chk8("R1", bus_rdata, 8'h00);
    cyc(0, 0, 3, 0, 0); chk8("R1", bus_rdata, 8'h00);
    // R2 edge capture and hold
    cyc(8'h20, 0, 3, 0, 0); chk8("R2", bus_rdata, 8'h20); chk8("R5", 8'(cpu_irq), 1);
    cyc(8'h00, 0, 3, 0, 0); chk8("R2", bus_rdata, 8'h20);
    cyc(8'h00, 0, 2, 0, 1); chk8("R6", vec_num, 8'h05); chk8("R6", bus_rdata, 8'h20);
    cyc(8'h00, 1, 2, 0, 0); chk8("R7", bus_rdata, 8'h00);
    // R2 no recapture while held high
    cyc(8'h08, 0, 3, 0, 0); chk8("R2", bus_rdata, 8'h08);
    cyc(8'h08, 0, 3, 0, 1); chk8("R2", bus_rdata, 8'h00);
    cyc(8'h08, 0, 3, 0, 0); chk8("R2", bus_rdata, 8'h00);
    cyc(8'h00, 1, 2, 0, 0);
    cyc(8'h08, 0, 3, 0, 0); chk8("R2", bus_rdata, 8'h08);
    cyc(8'h00, 0, 3, 0, 1);
    cyc(8'h00, 1, 2, 0, 0);
    // R9 configuration, base 21
    cyc(0, 1, 1, 8'hAE, 0); chk8("R9", bus_rdata, 8'hA8);
    // R5 priority ordering
    cyc(8'h44, 0, 3, 0, 0);
    cyc(8'h00, 0, 2, 0, 1); chk8("R6", vec_num, 8'hAA); chk8("R5", 8'(cpu_irq), 0);
    cyc(8'h00, 1, 2, 0, 0); chk8("R5", 8'(cpu_irq), 1);
    cyc(8'h00, 0, 2, 0, 1); chk8("R6", vec_num, 8'hAE);
    cyc(8'h02, 0, 2, 0, 0); chk8("R5", 8'(cpu_irq), 1);
    cyc(8'h00, 0, 2, 0, 1); chk8("R7", bus_rdata, 8'h42); chk8("R6", vec_num, 8'hA9);
    cyc(8'h00, 1, 2, 0, 0); chk8("R7", bus_rdata, 8'h40);
    cyc(8'h00, 1, 2, 0, 0); chk8("R7", bus_rdata, 8'h00);
    // R4 masking
    cyc(8'h00, 1, 0, 8'h10, 0);
    cyc(8'h10, 0, 3, 0, 0); chk8("R4", bus_rdata, 8'h10); chk8("R4", 8'(cpu_irq), 0);
    cyc(8'h00, 1, 0, 8'h00, 0); chk8("R4", 8'(cpu_irq), 1);
    cyc(8'h00, 0, 2, 0, 1);
    cyc(8'h00, 1, 2, 0, 0);
    // R8 command and acknowledge together
    cyc(8'h40, 0, 2, 0, 0);
    cyc(8'h00, 0, 2, 0, 1);
    cyc(8'h01, 0, 2, 0, 0); chk8("R5", 8'(cpu_irq), 1);
    cyc(8'h00, 1, 2, 0, 1); chk8("R8", bus_rdata, 8'h01);
    cyc(8'h00, 1, 2, 0, 0); chk8("R8", bus_rdata, 8'h00);
    // R6 acknowledge with no interrupt, R7 empty command
    cyc(8'h00, 0, 2, 0, 1); chk8("R6", 8'(vec_valid), 0); chk8("R6", bus_rdata, 8'h00);
    cyc(8'h00, 1, 2, 0, 0); chk8("R7", bus_rdata, 8'h00);
    // R10 writes to request address ignored
    cyc(8'h00, 1, 3, 8'hFF, 0); chk8("R10", bus_rdata, 8'h00);
    cyc(8'h00, 0, 0, 0, 0); chk8("R10", bus_rdata, 8'h00);
    cyc(8'h00, 0, 1, 0, 0); chk8("R10", bus_rdata, 8'hA8);
    // R3 level capture
    cyc(8'h00, 1, 1, 8'h01, 0);
    cyc(8'h81, 0, 3, 0, 0); chk8("R3", bus_rdata, 8'h81);
    cyc(8'h81, 0, 3, 0, 1); chk8("R3", bus_rdata, 8'h81); chk8("R6", vec_num, 8'h00);
    cyc(8'h80, 0, 3, 0, 0); chk8("R3", bus_rdata, 8'h80);
    cyc(8'h00, 1, 2, 0, 0); chk8("R3", bus_rdata, 8'h00);
    cyc(8'h00, 1, 1, 8'h00, 0);
    // random phase with per-cycle comparison
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] ir;
      logic       wr;
      ir = irq_lines ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
      wr = ($urandom % 6) == 0;
      cyc(ir, wr, 2'($urandom), 8'($urandom), ($urandom % 3) == 0);
    end
    finish_run();
  end
endmodule